// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches 48 digital input lines, arranged as six groups of eight, and presents them to a host through an 8-byte register window with a byte-wide data bus. The host can read the present level of any group. For each group it can also arm change-of-state detection. When any line in an armed group rises or falls, the block latches a flag for that group and raises an interrupt request.

The host's interrupt service reads the control/status byte at offset 7. That byte reports which groups changed and carries an active-low pending bit. The same read acknowledges the flags it returned. Every input passes through a two-flop synchroniser. Edge detection and the data registers both use the synchronised copy, so asynchronous field signals can be wired straight to the inputs.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, rdata_o is 0x00, irq_o is 0, all group enables are 0 and no status flag is set, so a first read of offset 7 returns 0x40.
- R2: A read of offset 0, 1, 2, 4, 5 or 6 returns group 0, 1, 2, 3, 4 or 5 respectively. Bit n of that byte is line 8*group+n, taken from the two-flop synchronised copy. A line change is visible to a read strobe issued two cycles after it is driven.
- R3: A read of offset 3 returns 0x00, and bit 7 of the offset 7 byte always reads 0.
- R4: A write to offset 7 loads wdata_i[5:0] into the group enable mask, where bit k arms group k. A write to any other offset has no effect.
- R5: A rising or a falling transition on any line of an armed group sets that group's status flag. The flag appears on the third clock edge after the line changes.
- R6: A transition on a group whose enable bit is 0 is not latched. Writing 0 to an enable bit clears that group's flag at the same edge, so writing 0x00 to offset 7 leaves no interrupt pending.
- R7: A read of offset 7 returns the latched flags in bits 5:0 and clears them at the same edge, which drops irq_o.
- R8: Bit 6 of the offset 7 byte reads 0 while the interrupt is asserted and 1 otherwise.
- R9: irq_o is 1 exactly when at least one group flag is set.
- R10: A change that is latched at the same edge as a clearing read of offset 7 stays set after that read.
- R11: rdata_o is updated only on a cycle with rd_i high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 48 | Asynchronous input lines |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A line change reaches the data registers two edges after it is driven. A status flag and irq_o follow on the third edge. Read data appears one edge after the strobe, and a clearing read drops irq_o at that same edge. The bench drives inputs on falling edges and steps a behavioural model on each rising edge. It compares rdata_o and irq_o on every falling edge. The directed checks wait the stated number of edges before sampling, and one case places a new change exactly on the edge of a clearing read.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned GROUPS   = 6;
  localparam int unsigned GW       = 8;
  localparam int unsigned AW       = 3;
  localparam int unsigned LINES    = GROUPS * GW;
  localparam logic [AW-1:0] CTRL_OFF = 3'd7;
  localparam logic [AW-1:0] HOLE_OFF = 3'd3;
  localparam int unsigned PEND_BIT = 6;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cos_grp_latch.sv
module cos_grp_latch #(
  parameter int unsigned GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] sync_i,
  input  logic          en_nxt_i,
  input  logic          clr_i,
  output logic          stat_o
);
  logic [GW-1:0] prev_q;
  logic          stat_q, chg;

  assign chg = |(sync_i ^ prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      // new change survives a clearing read; disable wipes the flag
      stat_q <= en_nxt_i & ((stat_q & ~clr_i) | chg);
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
  import cos_pkg::*;
#(
  parameter int unsigned NG = GROUPS,
  parameter int unsigned BW = GW
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NG*BW-1:0] data_i,
  input  logic [NG-1:0]    stat_i,
  input  logic             irq_i,
  output logic [BW-1:0]    byte_o
);
  always_comb begin
    byte_o = '0;
    if (addr_i == CTRL_OFF) begin
      byte_o[NG-1:0] = stat_i;
      byte_o[PEND_BIT] = ~irq_i;
    end else if (addr_i != HOLE_OFF) begin
      // offsets above the hole shift down by one group
      byte_o = data_i[((addr_i > HOLE_OFF) ? int'(addr_i) - 1 : int'(addr_i)) * BW +: BW];
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int unsigned NG = GROUPS,
  parameter int unsigned BW = GW,
  localparam int unsigned NL = NG * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] lines_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NL-1:0] sync;
  logic [NG-1:0] en_q, en_nxt, stat_q;
  logic [BW-1:0] rd_byte, rdata_q;
  logic          ctrl_wr, ctrl_rd;

  assign ctrl_wr = wr_i && (addr_i == CTRL_OFF);
  assign ctrl_rd = rd_i && (addr_i == CTRL_OFF);
  assign en_nxt  = ctrl_wr ? wdata_i[NG-1:0] : en_q;

  cos_sync #(.W(NL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_i),
    .q_o   (sync)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cos_grp_latch #(.GW(BW)) u_lat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[g*BW +: BW]),
      .en_nxt_i(en_nxt[g]),
      .clr_i   (ctrl_rd),
      .stat_o  (stat_q[g])
    );
  end

  cos_rd_mux #(.NG(NG), .BW(BW)) u_mux (
    .addr_i(addr_i),
    .data_i(sync),
    .stat_i(stat_q),
    .irq_i (irq_o),
    .byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (rd_i) rdata_q <= rd_byte;
    end
  end

  assign irq_o   = |stat_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int unsigned NG = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          irq_o,
  input logic [NG-1:0] stat_i,
  input logic [NG-1:0] en_i
);
  AST_PEND_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd7) |=> (rdata_o[6] == !$past(irq_o))); // R8
  AST_BIT7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd7) |=> !rdata_o[7]); // R3
  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd3) |=> (rdata_o == 8'h00)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R11
  AST_STATUS_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd7) |=> (rdata_o[NG-1:0] == $past(stat_i))); // R7
  AST_DISABLED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~en_i) == '0); // R6
  AST_OFF_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd7 && wdata_i[NG-1:0] == '0) |=> !irq_o); // R6
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NG(NG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .stat_i (stat_q),
  .en_i   (en_q)
);

// File: tb/cos_irq_ctrl_test.sv
module cos_irq_ctrl_test;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [47:0] lines_i = '0;
  logic [2:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int n_chk = 0, n_err = 0;

  cos_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(lines_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  // behavioural reference: line history queue, flags, enables
  logic [47:0] hist[$];
  logic [5:0]  m_stat, m_en;
  logic [7:0]  m_rdata;
  string       m_tag;

  function automatic logic [7:0] ref_byte(input logic [2:0] a, input logic [47:0] v,
                                          input logic [5:0] st);
    if (a == 3'd7) return {1'b0, (st == 6'd0), st};
    if (a == 3'd3) return 8'h00;
    if (a < 3'd3)  return v[a*8 +: 8];
    return v[(a-1)*8 +: 8];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{48'h0, 48'h0, 48'h0};
      m_stat = '0; m_en = '0; m_rdata = '0; m_tag = "R1";
    end else begin
      logic [5:0] en_n, changed;
      logic [47:0] seen, older;
      older = hist[0];
      seen  = hist[1];
      for (int g = 0; g < 6; g++) changed[g] = (seen[g*8 +: 8] != older[g*8 +: 8]);
      en_n = (wr_i && addr_i == 3'd7) ? wdata_i[5:0] : m_en;
      if (rd_i) begin
        m_rdata = ref_byte(addr_i, seen, m_stat);
        m_tag = (addr_i == 3'd7) ? "R7" : (addr_i == 3'd3) ? "R3" : "R2";
      end
      m_stat = en_n & (((rd_i && addr_i == 3'd7) ? 6'd0 : m_stat) | changed);
      m_en = en_n;
      void'(hist.pop_front());
      hist.push_back(lines_i);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_chk += 2;
      if (irq_o !== (m_stat != 0)) begin
        n_err++;
        $display("FAIL R9 cycle irq_o got %0b exp %0b", irq_o, m_stat != 0);
      end
      if (rdata_o !== m_rdata) begin
        n_err++;
        $display("FAIL %s/R11 cycle rdata_o got %02h exp %02h", m_tag, rdata_o, m_rdata);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    check("R1 rdata", rdata_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    rd(3'd7, v); check("R1 status", v, 8'h40);

    // R2 group map
    lines_i = 48'h665544_332211;
    tick(2);
    rd(3'd0, v); check("R2 g0", v, 8'h11);
    rd(3'd1, v); check("R2 g1", v, 8'h22);
    rd(3'd2, v); check("R2 g2", v, 8'h33);
    rd(3'd4, v); check("R2 g3", v, 8'h44);
    rd(3'd5, v); check("R2 g4", v, 8'h55);
    rd(3'd6, v); check("R2 g5", v, 8'h66);
    rd(3'd3, v); check("R3 hole", v, 8'h00);

    // R4 writes elsewhere ignored
    wr(3'd2, 8'h3F); wr(3'd0, 8'hFF);
    lines_i[0] = ~lines_i[0];
    tick(4);
    check("R4 no enable", {7'b0, irq_o}, 8'h00);
    rd(3'd7, v); check("R4 status", v, 8'h40);

    // R5 rising edge, group 0 armed
    wr(3'd7, 8'h05);
    tick(3);
    lines_i[3] = 1'b1;
    tick(2);
    check("R5 not yet", {7'b0, irq_o}, 8'h00);
    tick(1);
    check("R5 rise irq", {7'b0, irq_o}, 8'h01);
    rd(3'd7, v); check("R7/R8 status", v, 8'h01);
    check("R7 irq dropped", {7'b0, irq_o}, 8'h00);
    rd(3'd7, v); check("R8 idle", v, 8'h40);

    // R5 falling edge on group 2
    lines_i[17] = 1'b0;
    tick(4);
    rd(3'd7, v); check("R5 fall", v, 8'h04);

    // R6 disabled group 1
    lines_i[9] = ~lines_i[9];
    tick(4);
    check("R6 disabled", {7'b0, irq_o}, 8'h00);

    // R6 clearing enable clears flag
    wr(3'd7, 8'h07);
    lines_i[10] = ~lines_i[10];
    tick(4);
    check("R9 irq set", {7'b0, irq_o}, 8'h01);
    wr(3'd7, 8'h05);
    check("R6 cleared", {7'b0, irq_o}, 8'h00);
    lines_i[0] = ~lines_i[0];
    tick(4);
    wr(3'd7, 8'h00);
    rd(3'd7, v); check("R6 all off", v, 8'h40);

    // R10 change on the clearing edge
    wr(3'd7, 8'h01);
    lines_i[1] = ~lines_i[1];
    tick(4);
    lines_i[2] = ~lines_i[2];
    tick(2);
    rd(3'd7, v); check("R10 first read", v, 8'h01);
    check("R10 kept", {7'b0, irq_o}, 8'h01);
    rd(3'd7, v); check("R10 second read", v, 8'h01);
    check("R10 drained", {7'b0, irq_o}, 8'h00);

    // R11 hold without strobe
    rd(3'd0, v);
    lines_i[7:0] = ~lines_i[7:0];
    wr(3'd7, 8'h00);
    tick(4);
    check("R11 hold", rdata_o, v);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule